// File: doc/BRIEF.md
# Third-Order Bitstream Integrator Pin

This block accepts a one-bit delta-sigma stream and runs it through three cascaded integrators that update on every clock. The bit comes either straight from an on-chip modulator or from an external modulator pin. The external pin passes through a two-flop synchronizer first. Each integrator is a 32-bit register that wraps modulo 2^32. The first stage adds one for every high bit. Each later stage adds the value the stage before it held on the previous clock.

A period counter, set by the host, fixes the decimation ratio R. At the end of every R clocks the value of the last stage is copied into a report register, and `report_valid` pulses. The integrators are never cleared, so no input bit is lost between two reports. A later differencing stage in software turns consecutive wrapped reports into readings. The gain is R^3, so R is limited to 1625; this keeps a full-scale reading inside 32 bits.

The host writes the period through a small write port. It reads the report, the two lower stages or the active period through a read mux. A read of the report acknowledges it. A report that is replaced before it was acknowledged sets a sticky overrun flag.

Top module: `tri_integ_pin`

## Requirements
- R1: Stage 1 adds 1 on each clock where the selected bit is high and 0 where it is low. Stage 2 adds the previous stage-1 value and stage 3 adds the previous stage-2 value, all on the same edge. After n clocks of constant ones from reset, the stages hold n, n(n-1)/2 and n(n-1)(n-2)/6.
- R2: Every accumulator is 32 bits wide and wraps modulo 2^32 without saturating.
- R3: The period register accepts a write (`per_wr`=1) only for values from 1 to 1625. A value of 0 or above 1625 is ignored and the old period is kept. The active period reads back zero-extended on `rd_data` when `rd_sel`=3.
- R4: After reset, or after an accepted period write, the report is taken at every P-th clock edge, where P is the period. At that edge the stage-3 value after the edge is latched. `report_valid` is high in the cycle that follows the edge. `rd_sel`=0 shows the latched value, and it holds until the next report. No accumulator is cleared by a report.
- R5: With `src_sel`=0 the integrators take `adc_bit` with no delay. With `src_sel`=1 they take `ext_bit` through a two-flop synchronizer, so a change on `ext_bit` first reaches stage 1 three edges later. The unselected source has no effect.
- R6: `rd_sel`=1 shows the live stage-1 value and `rd_sel`=2 the live stage-2 value.
- R7: A clock with `rd_en`=1 and `rd_sel`=0 acknowledges the pending report. If a report is latched while the previous one is still unacknowledged, `overrun` goes high one cycle later. It stays high until reset.
- R8: A synchronous active-low reset clears all accumulators, the period counter, the report, `report_valid` and `overrun`, and sets the period to 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adc_bit | input | 1 | On-chip modulator bit |
| ext_bit | input | 1 | External modulator bit (asynchronous) |
| src_sel | input | 1 | 0 selects adc_bit, 1 selects ext_bit |
| per_wr | input | 1 | Period write strobe |
| per_wdata | input | 16 | Period value to write |
| rd_en | input | 1 | Read strobe; with rd_sel=0 it acknowledges the report |
| rd_sel | input | 2 | 0 report, 1 stage 1, 2 stage 2, 3 period |
| rd_data | output | 32 | Selected read value |
| report_valid | output | 1 | One-cycle pulse after each report edge |
| overrun | output | 1 | Sticky flag for an unacknowledged report that was replaced |

## Verification
Accumulators, period and report are registers, so each is due on the cycle after the edge that updates it. The bench drives inputs and samples outputs at falling edges, so the value it reads at a falling edge reflects the rising edge just before. `rd_data` is a combinational mux, so the bench reads it shortly after changing `rd_sel`, still before the next rising edge. Report spacing is checked by counting falling edges from the accepted write to each `report_valid`. External input has two cycles of synchronizer latency, so stage 1 changes on the third edge. The reference model in the bench carries the same delay.

// File: rtl/tip_pkg.sv
// Package: shared read-select encoding and limits for the integrator pin.
// Assumes nothing beyond a 2-bit read select on the top-level port.
package tip_pkg;

    // Read mux selection codes (field position is the rd_sel port, bits 1:0)
    typedef enum logic [1:0] {
        SEL_REPORT = 2'd0,
        SEL_STAGE1 = 2'd1,
        SEL_STAGE2 = 2'd2,
        SEL_PERIOD = 2'd3
    } rd_sel_t;

    // Largest period whose cube still fits in 32 bits
    localparam int unsigned PERIOD_LIMIT = 1625;

endpackage

// File: rtl/tip_bit_src.sv
// Module: tip_bit_src
// Picks the bit that feeds the integrators. The on-chip modulator bit is
// used directly; the external pin bit passes through SYNC_STAGES flops.
// Assumes adc_bit is already synchronous to clk.
module tip_bit_src #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adc_bit,
    input  logic ext_bit,
    input  logic src_sel,
    output logic bit_o
);

    logic ext_s;

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign ext_s = ext_bit;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] sync_q;

            // Shift the external bit through the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sync_q <= '0;
                end else begin
                    sync_q[0] <= ext_bit;
                    for (int i = 1; i < SYNC_STAGES; i++) begin
                        sync_q[i] <= sync_q[i-1];
                    end
                end
            end

            assign ext_s = sync_q[SYNC_STAGES-1];
        end
    endgenerate

    // Source select
    always_comb begin
        bit_o = src_sel ? ext_s : adc_bit;
    end

endmodule

// File: rtl/tip_integ_chain.sv
// Module: tip_integ_chain
// STAGES cascaded modulo-2^ACC_W integrators. Stage 0 counts high bits;
// each later stage adds the previous-cycle value of the stage before it.
// Assumes STAGES >= 2. Nothing is ever cleared except by reset.
module tip_integ_chain #(
    parameter int ACC_W  = 32,
    parameter int STAGES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_i,
    output logic [ACC_W-1:0] stage1_o,
    output logic [ACC_W-1:0] stage2_o,
    output logic [ACC_W-1:0] tail_o,
    output logic [ACC_W-1:0] tail_nxt_o
);

    logic [ACC_W-1:0] acc_q   [STAGES];
    logic [ACC_W-1:0] acc_nxt [STAGES];

    // Next values: every stage uses the registered value of its neighbour
    always_comb begin
        acc_nxt[0] = acc_q[0] + {{(ACC_W-1){1'b0}}, bit_i};
        for (int g = 1; g < STAGES; g++) begin
            acc_nxt[g] = acc_q[g] + acc_q[g-1];
        end
    end

    // Register all stages together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < STAGES; g++) begin
                acc_q[g] <= '0;
            end
        end else begin
            for (int g = 0; g < STAGES; g++) begin
                acc_q[g] <= acc_nxt[g];
            end
        end
    end

    assign stage1_o   = acc_q[0];
    assign stage2_o   = acc_q[1];
    assign tail_o     = acc_q[STAGES-1];
    assign tail_nxt_o = acc_nxt[STAGES-1];

endmodule

// File: rtl/tip_period_ctl.sv
// Module: tip_period_ctl
// Holds the decimation period and counts clocks. wrap_o is high during the
// clock whose edge completes a period. An accepted write restarts the count
// and suppresses a wrap on that edge. Out-of-range writes are dropped.
module tip_period_ctl #(
    parameter int CFG_W      = 16,
    parameter int PER_W      = 11,
    parameter int MAX_PERIOD = 1625,
    parameter int DEF_PERIOD = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CFG_W-1:0] wdata_i,
    output logic [PER_W-1:0] period_o,
    output logic             wrap_o
);

    logic [PER_W-1:0] period_q;
    logic [PER_W-1:0] cnt_q;
    logic             accept;

    // A write is taken only when it lies in 1..MAX_PERIOD
    always_comb begin
        accept = wr_i && (wdata_i != '0) && (wdata_i <= CFG_W'(MAX_PERIOD));
    end

    // Wrap when the count reaches the last clock of the period
    always_comb begin
        wrap_o = (cnt_q == period_q - PER_W'(1)) && !accept;
    end

    // Period register and clock counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= PER_W'(DEF_PERIOD);
            cnt_q    <= '0;
        end else if (accept) begin
            period_q <= wdata_i[PER_W-1:0];
            cnt_q    <= '0;
        end else if (wrap_o) begin
            cnt_q    <= '0;
        end else begin
            cnt_q    <= cnt_q + PER_W'(1);
        end
    end

    assign period_o = period_q;

endmodule

// File: rtl/tip_report.sv
// Module: tip_report
// Latches the post-edge tail value on a wrap, pulses valid the cycle after,
// tracks whether the latched value was acknowledged and raises a sticky
// overrun when an unacknowledged report is replaced.
module tip_report #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap_i,
    input  logic [ACC_W-1:0] tail_nxt_i,
    input  logic             ack_i,
    output logic [ACC_W-1:0] rpt_o,
    output logic             valid_o,
    output logic             overrun_o
);

    logic [ACC_W-1:0] rpt_q;
    logic             valid_q;
    logic             pend_q;
    logic             ovr_q;

    // Report latch and valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpt_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= wrap_i;
            if (wrap_i) begin
                rpt_q <= tail_nxt_i;
            end
        end
    end

    // Pending flag: set by a new report, cleared by an acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (wrap_i) begin
            pend_q <= 1'b1;
        end else if (ack_i) begin
            pend_q <= 1'b0;
        end
    end

    // Sticky overrun: replaced before being acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (wrap_i && pend_q && !ack_i) begin
            ovr_q <= 1'b1;
        end
    end

    assign rpt_o     = rpt_q;
    assign valid_o   = valid_q;
    assign overrun_o = ovr_q;

endmodule

// File: rtl/tri_integ_pin.sv
// Module: tri_integ_pin
// Third-order bitstream integrator with periodic, non-clearing reports.
// Assumes the host acknowledges each report by a read with rd_sel = 0.
module tri_integ_pin #(
    parameter int ACC_W      = 32,
    parameter int STAGES     = 3,
    parameter int CFG_W      = 16,
    parameter int MAX_PERIOD = tip_pkg::PERIOD_LIMIT,
    parameter int DEF_PERIOD = 16,
    parameter int EXT_SYNC   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adc_bit,
    input  logic             ext_bit,
    input  logic             src_sel,
    input  logic             per_wr,
    input  logic [CFG_W-1:0] per_wdata,
    input  logic             rd_en,
    input  logic [1:0]       rd_sel,
    output logic [ACC_W-1:0] rd_data,
    output logic             report_valid,
    output logic             overrun
);

    import tip_pkg::*;

    localparam int PER_W = $clog2(MAX_PERIOD + 1);

    logic             bit_w;
    logic [ACC_W-1:0] stage1_w;
    logic [ACC_W-1:0] stage2_w;
    logic [ACC_W-1:0] tail_w;
    logic [ACC_W-1:0] tail_nxt_w;
    logic [PER_W-1:0] period_w;
    logic             wrap_w;
    logic [ACC_W-1:0] rpt_w;
    logic             ack_w;

    tip_bit_src #(
        .SYNC_STAGES (EXT_SYNC)
    ) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .adc_bit (adc_bit),
        .ext_bit (ext_bit),
        .src_sel (src_sel),
        .bit_o   (bit_w)
    );

    tip_integ_chain #(
        .ACC_W  (ACC_W),
        .STAGES (STAGES)
    ) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_i      (bit_w),
        .stage1_o   (stage1_w),
        .stage2_o   (stage2_w),
        .tail_o     (tail_w),
        .tail_nxt_o (tail_nxt_w)
    );

    tip_period_ctl #(
        .CFG_W      (CFG_W),
        .PER_W      (PER_W),
        .MAX_PERIOD (MAX_PERIOD),
        .DEF_PERIOD (DEF_PERIOD)
    ) u_period (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (per_wr),
        .wdata_i  (per_wdata),
        .period_o (period_w),
        .wrap_o   (wrap_w)
    );

    // Acknowledge: a read strobe aimed at the report
    always_comb begin
        ack_w = rd_en && (rd_sel_t'(rd_sel) == SEL_REPORT);
    end

    tip_report #(
        .ACC_W (ACC_W)
    ) u_report (
        .clk        (clk),
        .rst_n      (rst_n),
        .wrap_i     (wrap_w),
        .tail_nxt_i (tail_nxt_w),
        .ack_i      (ack_w),
        .rpt_o      (rpt_w),
        .valid_o    (report_valid),
        .overrun_o  (overrun)
    );

    // Host read mux
    always_comb begin
        unique case (rd_sel_t'(rd_sel))
            SEL_REPORT: rd_data = rpt_w;
            SEL_STAGE1: rd_data = stage1_w;
            SEL_STAGE2: rd_data = stage2_w;
            default:    rd_data = {{(ACC_W-PER_W){1'b0}}, period_w};
        endcase
    end

endmodule

// File: rtl/tri_integ_pin_chk.sv
// Module: tri_integ_pin_chk
// Property checker bound into tri_integ_pin. Observes internal taps only.
module tri_integ_pin_chk #(
    parameter int ACC_W      = 32,
    parameter int CFG_W      = 16,
    parameter int PER_W      = 11,
    parameter int MAX_PERIOD = 1625
) (
    input logic             clk,
    input logic             rst_n,
    input logic             report_valid,
    input logic             overrun,
    input logic             per_wr,
    input logic [CFG_W-1:0] per_wdata,
    input logic [PER_W-1:0] period_w,
    input logic [ACC_W-1:0] stage1_w,
    input logic [ACC_W-1:0] tail_w,
    input logic [ACC_W-1:0] rpt_w
);

    AST_STAGE1_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((stage1_w - $past(stage1_w)) <= ACC_W'(1)));  // R1
    AST_STAGE1_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stage1_w) == '1 && stage1_w != '1) |-> (stage1_w == '0));  // R2
    AST_PERIOD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (period_w != '0) && (period_w <= PER_W'(MAX_PERIOD)));  // R3
    AST_BAD_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (per_wr && (per_wdata == '0 || per_wdata > CFG_W'(MAX_PERIOD))) |=> $stable(period_w));  // R3
    AST_REPORT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        report_valid |-> (rpt_w == tail_w));  // R4
    AST_REPORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !report_valid |-> $stable(rpt_w));  // R4
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);  // R7

endmodule

bind tri_integ_pin tri_integ_pin_chk #(
    .ACC_W      (ACC_W),
    .CFG_W      (CFG_W),
    .PER_W      (PER_W),
    .MAX_PERIOD (MAX_PERIOD)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .report_valid (report_valid),
    .overrun      (overrun),
    .per_wr       (per_wr),
    .per_wdata    (per_wdata),
    .period_w     (period_w),
    .stage1_w     (stage1_w),
    .tail_w       (tail_w),
    .rpt_w        (rpt_w)
);

// File: tb/tri_integ_pin_tb.sv
// Bench for tri_integ_pin: vector table loop, then directed tests.
module tri_integ_pin_tb;

    localparam int CLK_PERIOD = 10;

    // Vector: [48:33] period, [32:17] 16-bit bit pattern, [16] source, [15:0] reports
    localparam logic [48:0] VEC [0:6] = '{
        {16'd16,   16'hFFFF, 1'b0, 16'd3},
        {16'd7,    16'hAAAA, 1'b0, 16'd4},
        {16'd1,    16'h0F0F, 1'b0, 16'd5},
        {16'd33,   16'h1248, 1'b1, 16'd3},
        {16'd100,  16'hFFFE, 1'b1, 16'd2},
        {16'd5,    16'h0000, 1'b0, 16'd3},
        {16'd1625, 16'h5555, 1'b0, 16'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adc_bit = 1'b0;
    logic        ext_bit = 1'b0;
    logic        src_sel = 1'b0;
    logic        per_wr = 1'b0;
    logic [15:0] per_wdata = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        report_valid;
    logic        overrun;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    // Pattern driver
    logic        auto_on = 1'b0;
    logic [15:0] pat = '0;
    logic [3:0]  idx = '0;

    // Reference integrators
    logic [31:0] m1, m2, m3;
    logic        e1, e2;

    always #(CLK_PERIOD/2) clk = ~clk;

    tri_integ_pin u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .adc_bit      (adc_bit),
        .ext_bit      (ext_bit),
        .src_sel      (src_sel),
        .per_wr       (per_wr),
        .per_wdata    (per_wdata),
        .rd_en        (rd_en),
        .rd_sel       (rd_sel),
        .rd_data      (rd_data),
        .report_valid (report_valid),
        .overrun      (overrun)
    );

    always @(negedge clk) begin
        if (auto_on) begin
            adc_bit <= pat[idx];
            ext_bit <= pat[idx];
            idx     <= idx + 4'd1;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m1 <= '0; m2 <= '0; m3 <= '0; e1 <= 1'b0; e2 <= 1'b0;
        end else begin
            e1 <= ext_bit;
            e2 <= e1;
            m1 <= m1 + {31'd0, (src_sel ? e2 : adc_bit)};
            m2 <= m2 + m1;
            m3 <= m3 + m2;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rdv(input logic [1:0] s, output logic [31:0] v);
        rd_sel = s;
        #1;
        v = rd_data;
        rd_sel = 2'd0;
    endtask

    task automatic do_reset();
        auto_on = 1'b0;
        rst_n = 1'b0;
        adc_bit = 1'b0; ext_bit = 1'b0; src_sel = 1'b0;
        per_wr = 1'b0; rd_en = 1'b0; rd_sel = 2'd0;
        repeat (3) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        longint      big;

        // ---- R8: reset state ----
        do_reset();
        chk("R8 valid in reset", {31'd0, report_valid}, 32'd0);
        chk("R8 overrun in reset", {31'd0, overrun}, 32'd0);
        rdv(2'd0, v); chk("R8 report in reset", v, 32'd0);
        rdv(2'd1, v); chk("R8 stage1 in reset", v, 32'd0);
        rdv(2'd3, v); chk("R8 period default", v, 32'd16);

        // ---- R1/R6/R4/R7/R2: constant ones from reset, period 16 ----
        adc_bit = 1'b1;
        rst_n = 1'b1;
        repeat (15) tick();
        chk("R4 no valid before 16th edge", {31'd0, report_valid}, 32'd0);
        tick();
        chk("R4 valid after 16th edge", {31'd0, report_valid}, 32'd1);
        rdv(2'd0, v); chk("R1 report n=16", v, 32'd560);
        rdv(2'd1, v); chk("R6 stage1 n=16", v, 32'd16);
        rdv(2'd2, v); chk("R6 stage2 n=16", v, 32'd120);
        tick();
        chk("R4 valid is one cycle", {31'd0, report_valid}, 32'd0);
        repeat (3) tick();
        rdv(2'd0, v); chk("R4 report held n=20", v, 32'd560);
        rdv(2'd1, v); chk("R4 integrators not cleared n=20", v, 32'd20);
        repeat (11) tick();
        chk("R7 no overrun after first report", {31'd0, overrun}, 32'd0);
        tick();
        chk("R7 overrun after unread report", {31'd0, overrun}, 32'd1);
        repeat (3008 - 32) tick();
        chk("R4 valid at n=3008", {31'd0, report_valid}, 32'd1);
        big = longint'(3008) * 3007 * 3006 / 6;
        rdv(2'd0, v); chk("R2 wrapped stage3 n=3008", v, big[31:0]);
        chk("R2 bench model agrees", m3, big[31:0]);
        chk("R7 overrun sticky", {31'd0, overrun}, 32'd1);

        // ---- Vector table: period, pattern, source, report count ----
        do_reset();
        rst_n = 1'b1;
        rd_en = 1'b1;
        for (int i = 0; i < 7; i++) begin
            int unsigned per;
            int unsigned cnt;
            int unsigned got;
            per = int'(VEC[i][48:33]);
            pat = VEC[i][32:17];
            src_sel = VEC[i][16];
            auto_on = 1'b1;
            per_wdata = VEC[i][48:33];
            per_wr = 1'b1;
            tick();
            per_wr = 1'b0;
            rdv(2'd3, v); chk("R3 legal period accepted", v, per);
            got = 0;
            cnt = 0;
            while (got < int'(VEC[i][15:0])) begin
                tick();
                cnt++;
                if (report_valid) begin
                    chk("R4 report spacing", cnt, per);
                    rdv(2'd0, v);
                    chk(src_sel ? "R5 report ext source" : "R4 report adc source", v, m3);
                    got++;
                    cnt = 0;
                end
            end
        end
        chk("R7 acknowledged reports give no overrun", {31'd0, overrun}, 32'd0);
        rd_en = 1'b0;
        auto_on = 1'b0;

        // ---- R3: illegal writes ignored ----
        per_wdata = 16'd0; per_wr = 1'b1; tick(); per_wr = 1'b0;
        rdv(2'd3, v); chk("R3 zero ignored", v, 32'd1625);
        per_wdata = 16'd1626; per_wr = 1'b1; tick(); per_wr = 1'b0;
        rdv(2'd3, v); chk("R3 1626 ignored", v, 32'd1625);
        per_wdata = 16'hFFFF; per_wr = 1'b1; tick(); per_wr = 1'b0;
        rdv(2'd3, v); chk("R3 0xFFFF ignored", v, 32'd1625);
        per_wdata = 16'd3; per_wr = 1'b1; tick(); per_wr = 1'b0;
        rdv(2'd3, v); chk("R3 small legal write", v, 32'd3);

        // ---- R5: external source latency and unselected source ----
        do_reset();
        src_sel = 1'b1;
        ext_bit = 1'b1;
        adc_bit = 1'b0;
        rst_n = 1'b1;
        repeat (2) tick();
        rdv(2'd1, v); chk("R5 ext not yet seen after 2 edges", v, 32'd0);
        tick();
        rdv(2'd1, v); chk("R5 ext seen after 3 edges", v, 32'd1);
        src_sel = 1'b0;
        repeat (4) tick();
        rdv(2'd1, v); chk("R5 unselected ext ignored", v, 32'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule